// File: doc/BRIEF.md
# Dual-CPU Scanline Counter with Display Status

This block keeps the vertical position of the display beam for a screen that two processors share. A cycle divider turns a stream of base-clock ticks into line steps, and a line counter walks through a frame of 263 lines, of which the first 192 are drawn. Each processor owns a 16-bit display status register and a 9-bit line compare value. The block keeps two flags in every status register, one for vertical blank and one for line match. When a processor has enabled them, it also raises that processor's interrupt request.

A processor loads its status register with a single write. The write updates only the enable and compare fields and leaves the flag bits as they were. The same write carries the 9-bit compare value, split across two fields of the word. Each processor also sees a 32-bit read word that holds its status in the lower half and the current line in the upper half. Interrupt requests are one-clock pulses. They are issued on the clock edge where the line counter moves to the line that caused them.

Top module: `scanline_timer`

## Requirements
- R1: While reset is held, and right after it is released, the line count, both status registers, both read words and all four interrupt outputs are zero. Both compare values are also zero.
- R2: The line count advances by one when CYCLES_PER_LINE ticks have been counted, and moves from line LINES_PER_FRAME-1 back to 0. With `tick` low the count holds. After ticks start from reset, line 1 appears CYCLES_PER_LINE clocks later.
- R3: Entering line VISIBLE_LINES sets status bit 0 (vertical blank) in both status registers. Entering line LINES_PER_FRAME-1 clears it in both.
- R4: When status bit 3 is set as a processor's register enters line VISIBLE_LINES, `vblank_irq` for that processor pulses high for exactly one clock, on the same edge where the line count changes. With bit 3 clear, no pulse occurs.
- R5: On every line entry, status bit 2 (line match) is set if the new line equals that processor's compare value, and cleared if it does not. If status bit 5 is set on a match, `match_irq` for that processor pulses for one clock.
- R6: A write gives status = (old & 0x0047) | (data & 0xFFB8). Bits 0, 1, 2 and 6 cannot be written, so a vertical-blank flag that is set survives a write whose bit 0 is zero.
- R7: A write sets the compare value to {data[7], data[15:8]}, so lines 256 to 262 can be matched.
- R8: `rd_word[c]` equals {line count zero-extended to 16 bits, status[c]}.
- R9: A write by one processor leaves the other processor's status, compare value and interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One base-clock cycle elapsed |
| wr_en | input | 2 | Per-processor status write strobe |
| wr_data | input | 2x16 | Per-processor status write data |
| line_count | output | 9 | Current line, 0 to LINES_PER_FRAME-1 |
| status | output | 2x16 | Per-processor display status register |
| rd_word | output | 2x32 | Per-processor 32-bit view: line count in upper half, status in lower |
| vblank_irq | output | 2 | Per-processor vertical-blank interrupt pulse |
| match_irq | output | 2 | Per-processor line-match interrupt pulse |

## Verification
The bench keeps the default frame of 263 lines with 192 visible lines, and shortens CYCLES_PER_LINE to 3. With that setting two full frames fit into a few thousand clocks. They include the wrap from the last line to line 0, a match above line 255 that needs compare bit 8, and a match on line 0 at the wrap. Holding `tick` low while the registers are configured exercises the hold behaviour. It also keeps the configuration writes apart from line steps.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

  localparam int STAT_W   = 16;
  localparam int CMP_W    = 9;

  // Bits a status write may not alter / may alter.
  localparam logic [STAT_W-1:0] KEEP_MASK = 16'h0047;
  localparam logic [STAT_W-1:0] TAKE_MASK = 16'hFFB8;

  localparam int BIT_VBLANK    = 0;
  localparam int BIT_MATCH     = 2;
  localparam int BIT_VBLANK_EN = 3;
  localparam int BIT_MATCH_EN  = 5;

  function automatic logic [STAT_W-1:0] merge_status(input logic [STAT_W-1:0] old_s,
                                                     input logic [STAT_W-1:0] wdat);
    return (old_s & KEEP_MASK) | (wdat & TAKE_MASK);
  endfunction

  function automatic logic [CMP_W-1:0] compare_from_write(input logic [STAT_W-1:0] wdat);
    return {wdat[7], wdat[15:8]};
  endfunction

  function automatic logic [31:0] pack_read(input logic [STAT_W-1:0] s,
                                            input logic [15:0] ln);
    return {ln, s};
  endfunction

endpackage

// File: rtl/line_sequencer.sv
module line_sequencer #(
  parameter int CYCLES_PER_LINE = 4260,
  parameter int LINES_PER_FRAME = 263,
  parameter int VISIBLE_LINES   = 192,
  localparam int CW = (CYCLES_PER_LINE > 1) ? $clog2(CYCLES_PER_LINE) : 1,
  localparam int LW = $clog2(LINES_PER_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [LW-1:0] line_q,
  output logic [LW-1:0] line_next,
  output logic          step,
  output logic          vb_enter,
  output logic          vb_leave
);

  logic [CW-1:0] cyc_q;
  logic          last_cycle;

  assign last_cycle = (cyc_q == CW'(CYCLES_PER_LINE - 1));
  assign step       = tick && last_cycle;
  assign line_next  = (line_q == LW'(LINES_PER_FRAME - 1)) ? '0 : line_q + 1'b1;
  assign vb_enter   = step && (line_next == LW'(VISIBLE_LINES));
  assign vb_leave   = step && (line_next == LW'(LINES_PER_FRAME - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      line_q <= '0;
    end else if (tick) begin
      if (last_cycle) begin
        cyc_q  <= '0;
        line_q <= line_next;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
  import scanline_pkg::*;
#(
  parameter int LW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [LW-1:0]     line_next,
  input  logic              vb_enter,
  input  logic              vb_leave,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat_q,
  output logic              vb_irq_q,
  output logic              lm_irq_q
);

  logic [CMP_W-1:0]  cmp_q;
  logic              line_eq;
  logic              line_hit;
  logic [STAT_W-1:0] stat_d;

  assign line_eq  = (16'(line_next) == 16'(cmp_q));
  assign line_hit = step && line_eq;

  always_comb begin
    stat_d = wr_en ? merge_status(stat_q, wr_data) : stat_q;
    if (vb_enter) stat_d[BIT_VBLANK] = 1'b1;
    if (vb_leave) stat_d[BIT_VBLANK] = 1'b0;
    if (step)     stat_d[BIT_MATCH]  = line_eq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= '0;
      cmp_q    <= '0;
      vb_irq_q <= 1'b0;
      lm_irq_q <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      if (wr_en) cmp_q <= compare_from_write(wr_data);
      vb_irq_q <= vb_enter && stat_q[BIT_VBLANK_EN];
      lm_irq_q <= line_hit && stat_q[BIT_MATCH_EN];
    end
  end

endmodule

// File: rtl/scanline_timer.sv
module scanline_timer
  import scanline_pkg::*;
#(
  parameter int CYCLES_PER_LINE = 4260,
  parameter int LINES_PER_FRAME = 263,
  parameter int VISIBLE_LINES   = 192,
  localparam int NUM_CPUS = 2,
  localparam int LW = $clog2(LINES_PER_FRAME)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic [NUM_CPUS-1:0]              wr_en,
  input  logic [NUM_CPUS-1:0][STAT_W-1:0]  wr_data,
  output logic [LW-1:0]                    line_count,
  output logic [NUM_CPUS-1:0][STAT_W-1:0]  status,
  output logic [NUM_CPUS-1:0][31:0]        rd_word,
  output logic [NUM_CPUS-1:0]              vblank_irq,
  output logic [NUM_CPUS-1:0]              match_irq
);

  logic [LW-1:0] line_next;
  logic          line_step;
  logic          vb_enter;
  logic          vb_leave;

  line_sequencer #(
    .CYCLES_PER_LINE(CYCLES_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .VISIBLE_LINES  (VISIBLE_LINES)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .line_q   (line_count),
    .line_next(line_next),
    .step     (line_step),
    .vb_enter (vb_enter),
    .vb_leave (vb_leave)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    cpu_status_unit #(.LW(LW)) stat_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (line_step),
      .line_next(line_next),
      .vb_enter (vb_enter),
      .vb_leave (vb_leave),
      .wr_en    (wr_en[c]),
      .wr_data  (wr_data[c]),
      .stat_q   (status[c]),
      .vb_irq_q (vblank_irq[c]),
      .lm_irq_q (match_irq[c])
    );
    assign rd_word[c] = pack_read(status[c], 16'(line_count));
  end

endmodule

// File: rtl/scanline_timer_chk.sv
module scanline_timer_chk #(
  parameter int LINES = 263,
  parameter int VIS   = 192,
  parameter int LW    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              vb_enter,
  input logic              vb_leave,
  input logic [LW-1:0]     line_count,
  input logic [1:0][15:0]  status,
  input logic [1:0]        wr_en,
  input logic [1:0]        vblank_irq,
  input logic [1:0]        match_irq
);

  p_line_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_count < LW'(LINES));

  p_hold_without_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(line_count));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && (line_count != LW'(LINES - 1)) |=> line_count == $past(line_count) + 1'b1);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && (line_count == LW'(LINES - 1)) |=> line_count == '0);

  p_vblank_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vb_enter |=> status[0][0] && status[1][0]);

  p_vblank_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vb_leave |=> !status[0][0] && !status[1][0]);

  p_vblank_irq_line0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq[0] |-> (line_count == LW'(VIS)) && status[0][0]);

  p_vblank_irq_line1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq[1] |-> (line_count == LW'(VIS)) && status[1][0]);

  p_vblank_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq[0] |=> !vblank_irq[0]);

  p_match_flag0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq[0] |-> status[0][2]);

  p_match_flag1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq[1] |-> status[1][2]);

  p_flags_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] && !step |=> (status[0][0] == $past(status[0][0])) &&
                          (status[0][2] == $past(status[0][2])));

endmodule

bind scanline_timer scanline_timer_chk #(
  .LINES(LINES_PER_FRAME),
  .VIS  (VISIBLE_LINES),
  .LW   (LW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (line_step),
  .vb_enter  (vb_enter),
  .vb_leave  (vb_leave),
  .line_count(line_count),
  .status    (status),
  .wr_en     (wr_en),
  .vblank_irq(vblank_irq),
  .match_irq (match_irq)
);

// File: tb/scanline_timer_tb_top.sv
module scanline_timer_tb_top;

  localparam int CPL   = 3;
  localparam int LINES = 263;
  localparam int VIS   = 192;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              tick;
  logic [1:0]        wr_en;
  logic [1:0][15:0]  wr_data;
  logic [8:0]        line_count;
  logic [1:0][15:0]  status;
  logic [1:0][31:0]  rd_word;
  logic [1:0]        vblank_irq;
  logic [1:0]        match_irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [10:0] exp_q[$];

  scanline_timer #(
    .CYCLES_PER_LINE(CPL),
    .LINES_PER_FRAME(LINES),
    .VISIBLE_LINES  (VIS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .line_count(line_count), .status(status), .rd_word(rd_word),
    .vblank_irq(vblank_irq), .match_irq(match_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected event: {cpu, kind (0 vblank, 1 match), line}
  function automatic logic [10:0] ev(input int cpu, input int kind, input int ln);
    return {cpu[0], kind[0], ln[8:0]};
  endfunction

  // Monitor: every interrupt pulse seen must be the next queued item.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 2; k++) begin
          if ((k == 1) ? match_irq[c] : vblank_irq[c]) begin
            if (exp_q.size() == 0) begin
              check((k == 1) ? "R5 unexpected match irq" : "R4 unexpected vblank irq",
                    32'(ev(c, k, int'(line_count))), 32'h7FF);
            end else begin
              check((k == 1) ? "R5 match irq" : "R4 vblank irq",
                    32'(ev(c, k, int'(line_count))), 32'(exp_q.pop_front()));
            end
          end
        end
      end
    end
  end

  task automatic cpu_write(input int c, input logic [15:0] d);
    wr_data[c] = d;
    wr_en[c]   = 1'b1;
    @(negedge clk);
    wr_en[c]   = 1'b0;
  endtask

  task automatic wait_line(input int ln);
    while (int'(line_count) != ln) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n;
    logic [8:0] held;
    rst_n = 1'b0; tick = 1'b0; wr_en = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 line in reset", 32'(line_count), 0);
    check("R1 status0 in reset", 32'(status[0]), 0);
    check("R1 status1 in reset", 32'(status[1]), 0);
    check("R1 irqs in reset", 32'({vblank_irq, match_irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 read word after reset", rd_word[0], 0);

    // Configure with ticks held off.
    cpu_write(0, 16'h642F);            // enables 3,5; compare 100; flag bits masked
    check("R6 write mask cpu0", 32'(status[0]), 32'h6428);
    cpu_write(1, 16'h04A0);            // enable 5; compare 260 (bit 8 from data[7])
    check("R6 write cpu1", 32'(status[1]), 32'h04A0);
    check("R9 cpu0 untouched by cpu1", 32'(status[0]), 32'h6428);
    check("R8 read word cpu0", rd_word[0], 32'h0000_6428);
    repeat (10) @(negedge clk);
    check("R2 hold without tick", 32'(line_count), 0);

    exp_q.push_back(ev(0, 1, 100));
    exp_q.push_back(ev(0, 0, VIS));
    exp_q.push_back(ev(1, 1, 260));
    tick = 1'b1;
    n = 0;
    while (line_count != 9'd1) begin @(negedge clk); n++; end
    check("R2 cycles per line", 32'(n), CPL);

    wait_line(100);
    check("R5 match flag cpu0", 32'(status[0]), 32'h642C);
    check("R9 no match cpu1", 32'(status[1]), 32'h04A0);
    wait_line(101);
    check("R5 match flag cleared", 32'(status[0]), 32'h6428);
    wait_line(VIS);
    check("R3 vblank set cpu0", 32'(status[0]), 32'h6429);
    check("R3 vblank set cpu1", 32'(status[1]), 32'h04A1);
    wait_line(200);
    cpu_write(0, 16'h6428);
    check("R6 vblank flag survives write", 32'(status[0]), 32'h6429);
    wait_line(260);
    check("R7 compare above 255", 32'(status[1]), 32'h04A5);
    check("R8 read word cpu1", rd_word[1], {16'd260, 16'h04A5});
    wait_line(LINES - 1);
    check("R3 vblank cleared cpu0", 32'(status[0]), 32'h6428);
    check("R3 vblank cleared cpu1", 32'(status[1]), 32'h04A0);

    cpu_write(0, 16'h0028);            // compare 0, both enables
    exp_q.push_back(ev(0, 1, 0));
    exp_q.push_back(ev(0, 0, VIS));
    exp_q.push_back(ev(1, 1, 260));
    wait_line(0);
    check("R2 wrap to zero", 32'(line_count), 0);
    check("R7 compare zero matches at wrap", 32'(status[0]), 32'h002C);
    wait_line(261);
    check("R4 R5 all expected irqs seen", 32'(exp_q.size()), 0);

    tick = 1'b0;
    @(negedge clk);
    held = line_count;
    repeat (20) @(negedge clk);
    check("R2 hold mid frame", 32'(line_count), 32'(held));
    finish_run();
  end

endmodule